// File: doc/BRIEF.md
# Dual-Target Two-Wire Slave Controller

This block is a two-wire serial bus slave that presents two logical targets behind one pair of bus pins. The first target is a byte-wide memory, held inside the block, that is addressed with two address bytes. Its pointer advances by itself after every data byte, so bursts of any length run through the array and wrap at the top. The second target is a register file that sits outside the block. It is addressed with a single byte, has its own pointer, and accepts only addresses 00h through 18h.

The bus lines are sampled by the system clock through a synchronizer. That clock must run at least eight times faster than SCL. The slave pulls SDA low through an open-drain enable, and it does so only while SCL is low. Two strap inputs let up to four of these blocks share one bus. The block itself handles Start and Stop detection, decoding of the first byte, the acknowledge policy, and byte shifting with the most significant bit first. The register file is reached through a simple port: an address, write data with a one-cycle write strobe, and combinational read data.

Top module: `dual_i2c_target`

## Requirements
- R1: The upper nibble of the first byte after a Start chooses the target: 1010b selects the memory and 1101b selects the register file. Any other value gets no ACK, and the slave ignores the bus until the next Start.
- R2: Bits 2:1 of the first byte must equal `dev_sel[1:0]`, or the byte gets no ACK. Bit 3 is ignored. Bit 0 set to 1 requests a read and set to 0 requests a write.
- R3: A memory write carries the high address byte first and then the low byte, ahead of any data. Address bits at or above MEM_AW are ignored.
- R4: The memory pointer moves up by one after each data byte, whether written or read. It wraps from 2^MEM_AW-1 to 0, and a burst may have any length.
- R5: A read carries no address and starts at the current pointer. A write that carries only an address, followed by a repeated Start and a read, gives a random read.
- R6: Transactions to the register target leave the memory pointer unchanged.
- R7: A register address above 18h gets a NACK. Every later byte is then ignored until the next Start.
- R8: The register pointer moves up by one after each byte. A write byte whose pointer has passed 18h gets a NACK and is not written. A read with the pointer past 18h returns 00h.
- R9: Every accepted write byte is acknowledged by holding SDA low during the ninth clock. Data travels most significant bit first.
- R10: During a read the slave sends eight bits and continues only if the master ACKs. After a master NACK the slave leaves SDA released until a new Start.
- R11: A Start or a Stop resets byte reception at any bit position. Both reset and a Stop leave SDA released.
- R12: The slave begins pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| dev_sel | input | 2 | Strap value compared with first-byte bits 2:1 |
| reg_addr | output | 8 | Register-file pointer |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Register read data for `reg_addr` |

## Verification
Each bus edge takes two synchronizer flops plus one edge-detect flop to reach the state register. As a result, SDA changes, ACKs and data bits appear about four system clocks after the SCL edge that causes them. The bench changes SDA a quarter bit period (ten clocks) after each SCL fall and samples SDA in the middle of SCL high, which is another ten clocks later. Every ACK and every read bit is therefore settled well before it is sampled. Expected ACK values and read bytes go into a queue before each byte is clocked, and the monitor pairs each one with the next observed value. Register writes are checked by reading them back over the bus.

// File: rtl/dit_pkg.sv
package dit_pkg;

    localparam logic [3:0] ID_MEM   = 4'b1010;
    localparam logic [3:0] ID_REG   = 4'b1101;
    localparam logic [7:0] REG_LAST = 8'h18;

    // Encoding 0 is the idle state so that a zero reset is idle.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RX     = 3'd1,
        ST_RXDONE = 3'd2,
        ST_ACK    = 3'd3,
        ST_TX     = 3'd4,
        ST_TXACK  = 3'd5,
        ST_TXNEXT = 3'd6
    } bus_st_e;

    typedef enum logic [2:0] {
        PH_DEV   = 3'd0,
        PH_MHI   = 3'd1,
        PH_MLO   = 3'd2,
        PH_MDATA = 3'd3,
        PH_RADDR = 3'd4,
        PH_RDATA = 3'd5
    } byte_ph_e;

endpackage

// File: rtl/dit_line_sync.sv
module dit_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_s,
    output logic start_evt,
    output logic stop_evt
);
    typedef struct packed {
        logic [STAGES-1:0] scl_m;
        logic [STAGES-1:0] sda_m;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t s_d, s_q;
    logic  scl_s;

    always_comb begin
        s_d       = s_q;
        s_d.scl_m = {s_q.scl_m[STAGES-2:0], scl_i};
        s_d.sda_m = {s_q.sda_m[STAGES-2:0], sda_i};
        s_d.scl_p = s_q.scl_m[STAGES-1];
        s_d.sda_p = s_q.sda_m[STAGES-1];
    end

    // Idle bus lines are high, so everything resets to one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_s     = s_q.scl_m[STAGES-1];
    assign sda_s     = s_q.sda_m[STAGES-1];
    assign scl_rise  = scl_s & ~s_q.scl_p;
    assign scl_fall  = ~scl_s & s_q.scl_p;
    assign start_evt = scl_s & s_q.scl_p & s_q.sda_p & ~sda_s;
    assign stop_evt  = scl_s & s_q.scl_p & ~s_q.sda_p & sda_s;

endmodule

// File: rtl/dit_mem.sv
module dit_mem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[addr] <= wdata;
    end

    assign rdata = store[addr];

endmodule

// File: rtl/dual_i2c_target.sv
module dual_i2c_target
    import dit_pkg::*;
#(
    parameter int MEM_AW      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [1:0] dev_sel,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    input  logic [7:0] reg_rdata
);
    localparam logic [MEM_AW-1:0] PTR_ONE = MEM_AW'(1);

    typedef struct packed {
        bus_st_e           state;
        byte_ph_e          phase;
        logic              tgt_reg;
        logic              rd;
        logic [2:0]        cnt;
        logic [7:0]        sr;
        logic              oe;
        logic [7:0]        hi;
        logic [MEM_AW-1:0] mem_ptr;
        logic [7:0]        reg_ptr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic scl_rise, scl_fall, sda_s, start_evt, stop_evt;
    logic mem_we;
    logic [7:0] mem_rdata;
    logic [7:0] tx_byte;
    logic reg_ok;
    logic id_mem, id_reg, sel_hit;
    logic [MEM_AW-1:0] mem_ptr_w;
    logic tgt_reg_w;

    dit_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    dit_mem #(.AW(MEM_AW), .DW(8)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (ctl_q.mem_ptr),
        .wdata (ctl_q.sr),
        .rdata (mem_rdata)
    );

    assign reg_ok  = (ctl_q.reg_ptr <= REG_LAST);
    assign tx_byte = ctl_q.tgt_reg ? (reg_ok ? reg_rdata : 8'h00) : mem_rdata;
    assign id_mem  = (ctl_q.sr[7:4] == ID_MEM);
    assign id_reg  = (ctl_q.sr[7:4] == ID_REG);
    assign sel_hit = (ctl_q.sr[2:1] == dev_sel);

    always_comb begin
        ctl_d  = ctl_q;
        mem_we = 1'b0;
        reg_we = 1'b0;
        if (stop_evt) begin
            ctl_d.state = ST_IDLE;
            ctl_d.oe    = 1'b0;
        end else if (start_evt) begin
            ctl_d.state = ST_RX;
            ctl_d.phase = PH_DEV;
            ctl_d.cnt   = 3'd0;
            ctl_d.oe    = 1'b0;
            ctl_d.rd    = 1'b0;
        end else begin
            unique case (ctl_q.state)
                ST_RX: begin
                    if (scl_rise) begin
                        ctl_d.sr = {ctl_q.sr[6:0], sda_s};
                        if (ctl_q.cnt == 3'd7) begin
                            ctl_d.state = ST_RXDONE;
                            ctl_d.cnt   = 3'd0;
                        end else begin
                            ctl_d.cnt = ctl_q.cnt + 3'd1;
                        end
                    end
                end
                ST_RXDONE: begin
                    if (scl_fall) begin
                        // Default is NACK: leave the bus until the next Start.
                        ctl_d.state = ST_IDLE;
                        unique case (ctl_q.phase)
                            PH_DEV: begin
                                if (sel_hit && (id_mem || id_reg)) begin
                                    ctl_d.state   = ST_ACK;
                                    ctl_d.oe      = 1'b1;
                                    ctl_d.tgt_reg = id_reg;
                                    ctl_d.rd      = ctl_q.sr[0];
                                    ctl_d.phase   = id_reg ? PH_RADDR : PH_MHI;
                                end
                            end
                            PH_MHI: begin
                                ctl_d.state = ST_ACK;
                                ctl_d.oe    = 1'b1;
                                ctl_d.hi    = ctl_q.sr;
                                ctl_d.phase = PH_MLO;
                            end
                            PH_MLO: begin
                                ctl_d.state   = ST_ACK;
                                ctl_d.oe      = 1'b1;
                                ctl_d.mem_ptr = MEM_AW'({ctl_q.hi, ctl_q.sr});
                                ctl_d.phase   = PH_MDATA;
                            end
                            PH_MDATA: begin
                                mem_we        = 1'b1;
                                ctl_d.state   = ST_ACK;
                                ctl_d.oe      = 1'b1;
                                ctl_d.mem_ptr = ctl_q.mem_ptr + PTR_ONE;
                            end
                            PH_RADDR: begin
                                if (ctl_q.sr <= REG_LAST) begin
                                    ctl_d.state   = ST_ACK;
                                    ctl_d.oe      = 1'b1;
                                    ctl_d.reg_ptr = ctl_q.sr;
                                    ctl_d.phase   = PH_RDATA;
                                end
                            end
                            PH_RDATA: begin
                                if (reg_ok) begin
                                    reg_we        = 1'b1;
                                    ctl_d.state   = ST_ACK;
                                    ctl_d.oe      = 1'b1;
                                    ctl_d.reg_ptr = ctl_q.reg_ptr + 8'd1;
                                end
                            end
                            default: ctl_d.state = ST_IDLE;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        ctl_d.cnt = 3'd0;
                        if (ctl_q.rd) begin
                            ctl_d.state = ST_TX;
                            ctl_d.sr    = tx_byte;
                            ctl_d.oe    = ~tx_byte[7];
                        end else begin
                            ctl_d.state = ST_RX;
                            ctl_d.oe    = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (ctl_q.cnt == 3'd7) begin
                            ctl_d.state = ST_TXACK;
                            ctl_d.oe    = 1'b0;
                            ctl_d.cnt   = 3'd0;
                            if (ctl_q.tgt_reg) begin
                                if (reg_ok) ctl_d.reg_ptr = ctl_q.reg_ptr + 8'd1;
                            end else begin
                                ctl_d.mem_ptr = ctl_q.mem_ptr + PTR_ONE;
                            end
                        end else begin
                            ctl_d.cnt = ctl_q.cnt + 3'd1;
                            ctl_d.sr  = {ctl_q.sr[6:0], 1'b0};
                            ctl_d.oe  = ~ctl_q.sr[6];
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) ctl_d.state = sda_s ? ST_IDLE : ST_TXNEXT;
                end
                ST_TXNEXT: begin
                    if (scl_fall) begin
                        ctl_d.state = ST_TX;
                        ctl_d.cnt   = 3'd0;
                        ctl_d.sr    = tx_byte;
                        ctl_d.oe    = ~tx_byte[7];
                    end
                end
                default: ctl_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign sda_oe    = ctl_q.oe;
    assign reg_addr  = ctl_q.reg_ptr;
    assign reg_wdata = ctl_q.sr;
    assign mem_ptr_w = ctl_q.mem_ptr;
    assign tgt_reg_w = ctl_q.tgt_reg;

endmodule

// File: rtl/dit_checks.sv
module dit_checks #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_i,
    input logic          sda_oe,
    input logic          reg_we,
    input logic [7:0]    reg_addr,
    input logic          mem_we,
    input logic [AW-1:0] mem_ptr,
    input logic          tgt_reg,
    input logic          stop_evt
);
    // R12: a new pull on SDA starts only while SCL is low
    a_r12_drive_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R8: register writes never leave the legal window
    a_r8_reg_write_range: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (reg_addr <= 8'h18));

    // R11: a Stop releases the data line
    a_r11_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);

    // R4: each memory write moves the pointer by one, modulo the array size
    a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_ptr == $past(mem_ptr) + AW'(1)));

    // R6: while the register target is active, the memory pointer holds
    a_r6_ptr_hold_reg: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_reg |=> $stable(mem_ptr));

endmodule

bind dual_i2c_target dit_checks #(.AW(MEM_AW)) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .mem_we   (mem_we),
    .mem_ptr  (mem_ptr_w),
    .tgt_reg  (tgt_reg_w),
    .stop_evt (stop_evt)
);

// File: tb/tb_dual_i2c_target.sv
module tb_dual_i2c_target;
    localparam int Q = 10;

    typedef struct {
        logic [7:0] val;
        string      tag;
        string      what;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] sel = 2'b10;
    logic       sda_oe, reg_we, sda_line;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic [7:0] rf [32];
    int         n_chk = 0;
    int         n_fail = 0;
    item_t      exp_q[$];
    logic [7:0] obs_q[$];

    always #2 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = rf[reg_addr[4:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) rf[i] <= 8'h00;
        end else if (reg_we) begin
            rf[reg_addr[4:0]] <= reg_wdata;
        end
    end

    dual_i2c_target dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .dev_sel   (sel),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );

    // Scoreboard monitor: pair each observed value with the oldest expectation.
    always @(negedge clk) begin
        item_t      e;
        logic [7:0] o;
        if (exp_q.size() > 0 && obs_q.size() > 0) begin
            e = exp_q.pop_front();
            o = obs_q.pop_front();
            n_chk++;
            if (o !== e.val) begin
                n_fail++;
                $display("FAIL %s %s: actual %02h expected %02h", e.tag, e.what, o, e.val);
            end
        end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, expv);
        end
    endtask

    task automatic clock_bit(input logic v, output logic s);
        sda_m = v; wq();
        scl_m = 1'b1; wq();
        s = sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    // nack_exp = 1 means the slave is expected to leave the ninth bit high.
    task automatic send_byte(input logic [7:0] b, input logic nack_exp, input string tag);
        logic s;
        exp_q.push_back('{val: {7'd0, nack_exp}, tag: tag, what: "ack bit"});
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        obs_q.push_back({7'd0, s});
    endtask

    task automatic recv_byte(input logic [7:0] expv, input logic m_ack, input string tag);
        logic       s;
        logic [7:0] d = 8'h00;
        exp_q.push_back('{val: expv, tag: tag, what: "read byte"});
        for (int i = 0; i < 8; i++) begin
            clock_bit(1'b1, s);
            d = {d[6:0], s};
        end
        obs_q.push_back(d);
        clock_bit(~m_ack, s);
    endtask

    initial begin
        logic s;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 reset sda_oe", {7'd0, sda_oe}, 8'h00);
        check("R11 reset reg_we", {7'd0, reg_we}, 8'h00);

        // Memory burst write at 0x0010 (R1, R2, R3, R9)
        bus_start();
        send_byte(8'hA4, 1'b0, "R1");
        send_byte(8'h00, 1'b0, "R3");
        send_byte(8'h10, 1'b0, "R3");
        send_byte(8'h11, 1'b0, "R9");
        send_byte(8'h22, 1'b0, "R9");
        send_byte(8'h33, 1'b0, "R9");
        send_byte(8'h44, 1'b0, "R9");
        send_byte(8'h55, 1'b0, "R4");
        bus_stop();
        check("R11 after stop sda_oe", {7'd0, sda_oe}, 8'h00);

        // Random read: address-only write, repeated Start, read (R5, R10)
        bus_start();
        send_byte(8'hA4, 1'b0, "R5");
        send_byte(8'h00, 1'b0, "R5");
        send_byte(8'h10, 1'b0, "R5");
        bus_start();
        send_byte(8'hA5, 1'b0, "R2");
        recv_byte(8'h11, 1'b1, "R5");
        recv_byte(8'h22, 1'b1, "R4");
        recv_byte(8'h33, 1'b0, "R10");
        bus_stop();

        // Current-address read continues at 0x13 (R5)
        bus_start();
        send_byte(8'hA5, 1'b0, "R5");
        recv_byte(8'h44, 1'b0, "R5");
        bus_stop();

        // Register burst write from 0x17; third byte lands past 0x18 (R8)
        bus_start();
        send_byte(8'hD4, 1'b0, "R1");
        send_byte(8'h17, 1'b0, "R7");
        send_byte(8'h81, 1'b0, "R9");
        send_byte(8'h82, 1'b0, "R8");
        send_byte(8'h83, 1'b1, "R8");
        bus_stop();

        // Memory pointer unaffected by the register traffic (R6)
        bus_start();
        send_byte(8'hA5, 1'b0, "R6");
        recv_byte(8'h55, 1'b0, "R6");
        bus_stop();

        // Register read-back, running past 0x18 returns 00h (R8)
        bus_start();
        send_byte(8'hD4, 1'b0, "R1");
        send_byte(8'h17, 1'b0, "R7");
        bus_start();
        send_byte(8'hD5, 1'b0, "R2");
        recv_byte(8'h81, 1'b1, "R8");
        recv_byte(8'h82, 1'b1, "R8");
        recv_byte(8'h00, 1'b0, "R8");
        bus_stop();

        // Illegal register address, then abandoned transaction (R7)
        bus_start();
        send_byte(8'hD4, 1'b0, "R7");
        send_byte(8'h19, 1'b1, "R7");
        send_byte(8'h77, 1'b1, "R7");
        bus_stop();
        bus_start();
        send_byte(8'hD4, 1'b0, "R7");
        send_byte(8'h18, 1'b0, "R7");
        bus_stop();

        // Select and identity mismatches, bit 3 ignored (R1, R2)
        bus_start();
        send_byte(8'hA0, 1'b1, "R2");
        send_byte(8'h00, 1'b1, "R2");
        bus_stop();
        bus_start();
        send_byte(8'hB4, 1'b1, "R1");
        bus_stop();
        bus_start();
        send_byte(8'hAC, 1'b0, "R2");
        bus_stop();

        // Wrap from 0xFF to 0x00 with the high address byte ignored (R3, R4)
        bus_start();
        send_byte(8'hA4, 1'b0, "R3");
        send_byte(8'h37, 1'b0, "R3");
        send_byte(8'hFF, 1'b0, "R3");
        send_byte(8'h5A, 1'b0, "R4");
        send_byte(8'h6B, 1'b0, "R4");
        bus_stop();
        bus_start();
        send_byte(8'hA4, 1'b0, "R3");
        send_byte(8'h00, 1'b0, "R3");
        send_byte(8'hFF, 1'b0, "R3");
        bus_start();
        send_byte(8'hA5, 1'b0, "R5");
        recv_byte(8'h5A, 1'b1, "R3");
        recv_byte(8'h6B, 1'b0, "R4");
        // After the master NACK the slave must stay silent (R10)
        recv_byte(8'hFF, 1'b0, "R10");
        bus_stop();

        // A Stop in the middle of a byte resets reception (R11)
        bus_start();
        send_byte(8'hA4, 1'b0, "R5");
        send_byte(8'h00, 1'b0, "R5");
        send_byte(8'h12, 1'b0, "R5");
        bus_stop();
        bus_start();
        clock_bit(1'b1, s);
        clock_bit(1'b0, s);
        clock_bit(1'b1, s);
        clock_bit(1'b0, s);
        bus_stop();
        check("R11 mid-byte stop sda_oe", {7'd0, sda_oe}, 8'h00);
        bus_start();
        send_byte(8'hA5, 1'b0, "R11");
        recv_byte(8'h33, 1'b0, "R11");
        bus_stop();

        repeat (20) @(negedge clk);
        check("R9 scoreboard drained", 8'(exp_q.size() + obs_q.size()), 8'h00);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung, expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule